// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block generates the memory-request stream for a multi-register load or store. A single start pulse hands it a base address, a 16-bit mask of the registers taking part, a two-bit addressing mode, a write-back flag and a load/store flag. The block counts the set bits of the mask and computes the lowest word address of the transfer from the mode and that count. It then issues one word request per set bit on a valid/ready interface. Each request carries the word address and the register index.

Registers are always visited from the lowest index upward, and addresses always rise by one word per beat, including in the two decrementing modes. The mode only changes where the run starts and which base value is offered for write-back. When the last beat is accepted, the block raises a one-cycle done pulse. It also presents the updated base, and flags a control transfer when a load includes the top register. A small combinational path turns the word loaded into that register into an aligned fetch address and an instruction-set-state bit.

Top module: `blk_xfer_seq`

## Requirements
- R1: After reset, `busy_o`, `req_valid_o`, `done_o`, `wb_en_o` and `ctl_xfer_o` are all low.
- R2: `start_i` is taken only while `busy_o` is low; a start pulse during a transfer changes neither the remaining requests nor the final result.
- R3: A started transfer issues exactly one accepted request per set bit of `list_i`, with `req_idx_o` equal to the bit positions in strictly ascending order.
- R4: The first request address depends on `mode_i`, with n the number of set bits: 0 gives base, 1 gives base+4, 2 gives base−4n+4, and 3 gives base−4n (32-bit wrap-around arithmetic).
- R5: Each request after the first, within one transfer, carries the previous address plus 4.
- R6: While `req_valid_o` is high and `req_ready_i` is low, the next cycle keeps `req_valid_o` high and `req_addr_o` and `req_idx_o` unchanged.
- R7: `done_o` is high for exactly one cycle, in the cycle after the last request is accepted; in that cycle `req_valid_o` and `busy_o` are low.
- R8: A start with an all-zero list raises `done_o` in the next cycle and issues no request.
- R9: In the done cycle, `wb_en_o` equals the latched write-back flag. `wb_value_o` is base+4n for modes 0 and 1 and base−4n for modes 2 and 3.
- R10: In the done cycle, `ctl_xfer_o` is high exactly when the transfer was a load (`load_i`=1) and bit 15 of the list was set. `pc_target_o` equals `pc_word_i` with bit 0 cleared, and `pc_state_o` equals bit 0 of `pc_word_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| base_i | input | 32 | Base address |
| list_i | input | 16 | Register mask, bit k selects register k |
| mode_i | input | 2 | Addressing mode, 0..3 as in R4 |
| wback_i | input | 1 | Request base write-back |
| load_i | input | 1 | 1 for a load, 0 for a store |
| busy_o | output | 1 | Transfer in progress |
| req_valid_o | output | 1 | Memory request valid |
| req_ready_i | input | 1 | Memory request accepted |
| req_addr_o | output | 32 | Word address of the request |
| req_idx_o | output | 4 | Register index of the request |
| done_o | output | 1 | One-cycle completion pulse |
| wb_en_o | output | 1 | Write-back of the base register is due |
| wb_value_o | output | 32 | Updated base value |
| ctl_xfer_o | output | 1 | Load of register 15 completed |
| pc_word_i | input | 32 | Word loaded into register 15 |
| pc_target_o | output | 32 | Fetch address, bit 0 cleared |
| pc_state_o | output | 1 | Instruction-set-state bit taken from bit 0 |

## Verification
The assertions assume that the memory side never withdraws `req_ready_i` in a way that matters. Acceptance is judged only at the clock edge where valid and ready are both high. They also assume that `list_i` and `mode_i` are meaningful only in the cycle `start_i` is high. The bench changes these inputs only at falling edges. Right after each start it drives them to unrelated values, which shows that the block latches them. The bench raises `start_i` during a transfer only in a deliberate test of the idle-only rule. The ready input toggles under random duty cycles, so both held and streaming beats occur.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;

  // Addressing modes; the encoding is decoded by the address-span logic.
  typedef enum logic [1:0] {
    AM_UP_AFTER   = 2'd0,
    AM_UP_BEFORE  = 2'd1,
    AM_DN_AFTER   = 2'd2,
    AM_DN_BEFORE  = 2'd3
  } amode_e;

endpackage

// File: rtl/blk_xfer_popcnt.sv
module blk_xfer_popcnt #(
  parameter int LIST_W = 16,
  parameter int CNT_W  = $clog2(LIST_W + 1)
) (
  input  logic [LIST_W-1:0] vec_i,
  output logic [CNT_W-1:0]  cnt_o
);

  function automatic logic [CNT_W-1:0] ones(input logic [LIST_W-1:0] v);
    logic [CNT_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < LIST_W; i++) acc = acc + CNT_W'(v[i]);
    return acc;
  endfunction

  assign cnt_o = ones(vec_i);

endmodule

// File: rtl/blk_xfer_span.sv
module blk_xfer_span
  import blk_xfer_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 5,
  parameter int WORD_BYTES = 4
) (
  input  logic [ADDR_W-1:0] base_i,
  input  amode_e            mode_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [ADDR_W-1:0] first_o,
  output logic [ADDR_W-1:0] final_o
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  // Total bytes moved by the transfer.
  function automatic logic [ADDR_W-1:0] span(input logic [CNT_W-1:0] n);
    return ADDR_W'(n) * STEP;
  endfunction

  // Lowest word address touched, per mode.
  function automatic logic [ADDR_W-1:0] low_addr(input logic [ADDR_W-1:0] b,
                                                 input amode_e m,
                                                 input logic [CNT_W-1:0] n);
    case (m)
      AM_UP_AFTER:  return b;
      AM_UP_BEFORE: return b + STEP;
      AM_DN_AFTER:  return b - span(n) + STEP;
      AM_DN_BEFORE: return b - span(n);
      default:      return b;
    endcase
  endfunction

  // Base value offered for write-back.
  function automatic logic [ADDR_W-1:0] new_base(input logic [ADDR_W-1:0] b,
                                                 input amode_e m,
                                                 input logic [CNT_W-1:0] n);
    return m[1] ? (b - span(n)) : (b + span(n));
  endfunction

  assign first_o = low_addr(base_i, mode_i, cnt_i);
  assign final_o = new_base(base_i, mode_i, cnt_i);

endmodule

// File: rtl/blk_xfer_pick.sv
module blk_xfer_pick #(
  parameter int LIST_W = 16,
  parameter int IDX_W  = $clog2(LIST_W)
) (
  input  logic [LIST_W-1:0] vec_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [LIST_W-1:0] rest_o,
  output logic              last_o
);

  always_comb begin
    idx_o = '0;
    for (int i = LIST_W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end

  // Clear the lowest set bit.
  assign rest_o = vec_i & (vec_i - LIST_W'(1));
  assign last_o = (rest_o == '0);

endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import blk_xfer_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LIST_W     = 16,
  parameter int WORD_BYTES = 4,
  localparam int IDX_W     = $clog2(LIST_W),
  localparam int CNT_W     = $clog2(LIST_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LIST_W-1:0] list_i,
  input  logic [1:0]        mode_i,
  input  logic              wback_i,
  input  logic              load_i,
  output logic              busy_o,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [IDX_W-1:0]  req_idx_o,
  output logic              done_o,
  output logic              wb_en_o,
  output logic [ADDR_W-1:0] wb_value_o,
  output logic              ctl_xfer_o,
  input  logic [ADDR_W-1:0] pc_word_i,
  output logic [ADDR_W-1:0] pc_target_o,
  output logic              pc_state_o
);

  // State
  logic              busy_q;
  logic [LIST_W-1:0] rem_q;
  logic [ADDR_W-1:0] cur_q;
  logic [ADDR_W-1:0] wbv_q;
  logic              wbf_q;
  logic              ld_q;
  logic              top_q;
  logic              done_q;

  // Combinational helpers
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] first_addr;
  logic [ADDR_W-1:0] final_addr;
  logic [IDX_W-1:0]  pick_idx;
  logic [LIST_W-1:0] pick_rest;
  logic              pick_last;

  // Named events (also observed by the checker)
  logic accept;
  logic beat_fire;
  logic last_beat;
  logic empty_start;

  blk_xfer_popcnt #(.LIST_W(LIST_W), .CNT_W(CNT_W)) u_cnt (
    .vec_i (list_i),
    .cnt_o (cnt)
  );

  blk_xfer_span #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .WORD_BYTES(WORD_BYTES)) u_span (
    .base_i  (base_i),
    .mode_i  (amode_e'(mode_i)),
    .cnt_i   (cnt),
    .first_o (first_addr),
    .final_o (final_addr)
  );

  blk_xfer_pick #(.LIST_W(LIST_W), .IDX_W(IDX_W)) u_pick (
    .vec_i  (rem_q),
    .idx_o  (pick_idx),
    .rest_o (pick_rest),
    .last_o (pick_last)
  );

  assign accept      = start_i && !busy_q;
  assign empty_start = accept && (cnt == '0);
  assign beat_fire   = req_valid_o && req_ready_i;
  assign last_beat   = beat_fire && pick_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rem_q  <= '0;
      cur_q  <= '0;
      wbv_q  <= '0;
      wbf_q  <= 1'b0;
      ld_q   <= 1'b0;
      top_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        rem_q <= list_i;
        cur_q <= first_addr;
        wbv_q <= final_addr;
        wbf_q <= wback_i;
        ld_q  <= load_i;
        top_q <= list_i[LIST_W-1];
        if (empty_start) done_q <= 1'b1;
        else             busy_q <= 1'b1;
      end else if (beat_fire) begin
        rem_q <= pick_rest;
        cur_q <= cur_q + ADDR_W'(WORD_BYTES);
        if (pick_last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o      = busy_q;
  assign req_valid_o = busy_q;
  assign req_addr_o  = cur_q;
  assign req_idx_o   = pick_idx;
  assign done_o      = done_q;
  assign wb_en_o     = done_q && wbf_q;
  assign wb_value_o  = wbv_q;
  assign ctl_xfer_o  = done_q && ld_q && top_q;
  assign pc_target_o = {pc_word_i[ADDR_W-1:1], 1'b0};
  assign pc_state_o  = pc_word_i[0];

endmodule

// File: rtl/blk_xfer_chk.sv
module blk_xfer_chk #(
  parameter int ADDR_W     = 32,
  parameter int LIST_W     = 16,
  parameter int WORD_BYTES = 4,
  parameter int IDX_W      = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [LIST_W-1:0] list_i,
  input logic              busy_o,
  input logic              req_valid_o,
  input logic              req_ready_i,
  input logic [ADDR_W-1:0] req_addr_o,
  input logic [IDX_W-1:0]  req_idx_o,
  input logic              done_o,
  input logic              accept,
  input logic              beat_fire,
  input logic              last_beat
);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o) && $stable(req_idx_o))); // R6

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && !last_beat) |=> (req_addr_o == $past(req_addr_o) + ADDR_W'(WORD_BYTES))); // R5

  AST_IDX_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && !last_beat) |=> (req_valid_o && (req_idx_o > $past(req_idx_o)))); // R3

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |=> (done_o && !busy_o)); // R7

  AST_EMPTY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (list_i == '0)) |=> (done_o && !req_valid_o)); // R8

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !req_valid_o); // R7

endmodule

bind blk_xfer_seq blk_xfer_chk #(
  .ADDR_W(ADDR_W), .LIST_W(LIST_W), .WORD_BYTES(WORD_BYTES), .IDX_W(IDX_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .list_i      (list_i),
  .busy_o      (busy_o),
  .req_valid_o (req_valid_o),
  .req_ready_i (req_ready_i),
  .req_addr_o  (req_addr_o),
  .req_idx_o   (req_idx_o),
  .done_o      (done_o),
  .accept      (accept),
  .beat_fire   (beat_fire),
  .last_beat   (last_beat)
);

// File: tb/blk_xfer_seq_bench.sv
module blk_xfer_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [31:0] base_i;
  logic [15:0] list_i;
  logic [1:0]  mode_i;
  logic        wback_i;
  logic        load_i;
  logic        busy_o;
  logic        req_valid_o;
  logic        req_ready_i;
  logic [31:0] req_addr_o;
  logic [3:0]  req_idx_o;
  logic        done_o;
  logic        wb_en_o;
  logic [31:0] wb_value_o;
  logic        ctl_xfer_o;
  logic [31:0] pc_word_i;
  logic [31:0] pc_target_o;
  logic        pc_state_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  blk_xfer_seq u_blk_xfer_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i), .list_i(list_i),
    .mode_i(mode_i), .wback_i(wback_i), .load_i(load_i), .busy_o(busy_o),
    .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .req_addr_o(req_addr_o),
    .req_idx_o(req_idx_o), .done_o(done_o), .wb_en_o(wb_en_o), .wb_value_o(wb_value_o),
    .ctl_xfer_o(ctl_xfer_o), .pc_word_i(pc_word_i), .pc_target_o(pc_target_o),
    .pc_state_o(pc_state_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL R7 watchdog expired: actual %0d expected below %0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic int ones(input logic [15:0] l);
    int n = 0;
    for (int i = 0; i < 16; i++) n += int'(l[i]);
    return n;
  endfunction

  // Reference for R4: lowest address of the run.
  function automatic logic [31:0] exp_first(input logic [31:0] b, input logic [1:0] m, input int n);
    logic [31:0] bytes = 32'(n) << 2;
    case (m)
      2'd0: return b;
      2'd1: return b + 32'd4;
      2'd2: return b + 32'd4 - bytes;
      default: return b - bytes;
    endcase
  endfunction

  // Reference for R9: write-back value.
  function automatic logic [31:0] exp_final(input logic [31:0] b, input logic [1:0] m, input int n);
    logic [31:0] bytes = 32'(n) << 2;
    return (m >= 2'd2) ? b - bytes : b + bytes;
  endfunction

  task automatic run_xfer(input logic [31:0] base, input logic [15:0] list, input logic [1:0] mode,
                          input bit wb, input bit ld, input int rdy_pct, input bit poke);
    int n = ones(list);
    logic [31:0] want_addr = exp_first(base, mode, n);
    int want_idx = 0;
    int beats = 0;
    int guard = 0;
    bit prev_v = 0, prev_r = 0, poked = 0, rdy;
    logic [31:0] prev_addr = '0;
    logic [3:0]  prev_idx = '0;
    logic [31:0] pcw = $urandom;

    @(negedge clk);
    start_i = 1'b1; base_i = base; list_i = list; mode_i = mode;
    wback_i = wb; load_i = ld; req_ready_i = 1'b0; pc_word_i = pcw;
    @(negedge clk);
    start_i = 1'b0; base_i = ~base; list_i = ~list; mode_i = ~mode;
    wback_i = ~wb; load_i = ~ld;

    while (beats < n) begin
      if (guard++ > 400) begin
        check(0, "R3", "transfer stalled", 32'(beats), 32'(n));
        break;
      end
      check(req_valid_o === 1'b1, "R3", "valid during transfer", 32'(req_valid_o), 1);
      if (prev_v && !prev_r) begin
        check(req_addr_o === prev_addr, "R6", "address held", req_addr_o, prev_addr);
        check(req_idx_o === prev_idx, "R6", "index held", 32'(req_idx_o), 32'(prev_idx));
      end
      if (poke && beats == 1 && !poked) begin
        start_i = 1'b1; list_i = 16'h0000; mode_i = 2'd3; poked = 1;  // R2 ignored start
      end else begin
        start_i = 1'b0;
      end
      rdy = ($urandom_range(99) < rdy_pct);
      req_ready_i = rdy;
      if (rdy) begin
        while (!list[want_idx]) want_idx++;
        check(req_addr_o === want_addr, beats == 0 ? "R4" : "R5", "request address",
              req_addr_o, want_addr);
        check(req_idx_o === 4'(want_idx), "R3", "request index", 32'(req_idx_o), 32'(want_idx));
        want_addr += 32'd4;
        want_idx++;
        beats++;
      end
      prev_v = 1; prev_r = rdy; prev_addr = req_addr_o; prev_idx = req_idx_o;
      @(negedge clk);
    end
    req_ready_i = 1'b0;
    start_i = 1'b0;

    if (n == 0) check(req_valid_o === 1'b0, "R8", "no request for empty list", 32'(req_valid_o), 0);
    check(done_o === 1'b1, n == 0 ? "R8" : "R7", "done pulse", 32'(done_o), 1);
    check(req_valid_o === 1'b0 && busy_o === 1'b0, "R7", "idle at done",
          32'({req_valid_o, busy_o}), 0);
    check(wb_en_o === wb, "R9", "write-back enable", 32'(wb_en_o), 32'(wb));
    check(wb_value_o === exp_final(base, mode, n), "R9", "write-back value",
          wb_value_o, exp_final(base, mode, n));
    check(ctl_xfer_o === (ld && list[15]), "R10", "control transfer flag",
          32'(ctl_xfer_o), 32'(ld && list[15]));
    if (ld && list[15]) begin
      check(pc_target_o === {pcw[31:1], 1'b0}, "R10", "fetch address", pc_target_o, {pcw[31:1], 1'b0});
      check(pc_state_o === pcw[0], "R10", "state bit", 32'(pc_state_o), 32'(pcw[0]));
    end
    @(negedge clk);
    check(done_o === 1'b0, "R7", "done single cycle", 32'(done_o), 0);
    check(req_valid_o === 1'b0, poke ? "R2" : "R3", "no extra request", 32'(req_valid_o), 0);
  endtask

  initial begin
    logic [15:0] directed [7];
    directed = '{16'h0000, 16'h0001, 16'h8000, 16'hFFFF, 16'h5555, 16'hAAAA, 16'h8001};
    rst_n = 1'b0; start_i = 1'b0; base_i = '0; list_i = '0; mode_i = '0;
    wback_i = 1'b0; load_i = 1'b0; req_ready_i = 1'b0; pc_word_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy_o === 1'b0 && req_valid_o === 1'b0, "R1", "reset idle", 32'({busy_o, req_valid_o}), 0);
    check(done_o === 1'b0 && wb_en_o === 1'b0 && ctl_xfer_o === 1'b0, "R1", "reset outputs",
          32'({done_o, wb_en_o, ctl_xfer_o}), 0);

    for (int m = 0; m < 4; m++) begin
      for (int d = 0; d < 7; d++) begin
        run_xfer(32'h0000_1000 + 32'(d * 64), directed[d], 2'(m), 1'b1, 1'b1, 100, 1'b0);
        run_xfer($urandom, directed[d], 2'(m), d[0], 1'b1, 40, d == 3);
      end
      run_xfer(32'h0000_0000, 16'h00F0, 2'(m), 1'b1, 1'b0, 60, 1'b0);  // wrap-around base
      for (int k = 0; k < 60; k++) begin
        run_xfer($urandom, 16'($urandom), 2'(m), 1'($urandom), 1'($urandom),
                 (k % 3 == 0) ? 100 : ((k % 3 == 1) ? 50 : 25), (k % 5 == 0));
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule